// File: doc/BRIEF.md
# Standby Entry Controller with Locked Regulator Select

This block decides when a small processor subsystem may stop its main clock, and it sequences the return to normal running. Software programs it through a byte-wide register bus. A stop request is made by setting a control bit, and the request counts only if the mode field selects stop and no unmasked interrupt is already waiting. Once a request is taken, the block holds off for a settling interval and then gates the main clock. If a low-voltage option was armed beforehand, it also drops the regulator to its low level.

The low-voltage option sits behind a one-shot key. A magic byte written to the key register opens a window, and that window covers only the very next bus write. A write to the option register outside the window changes nothing and sets a sticky error flag. Software can read this flag, and it clears the flag by writing zero to the key register.

A wake input ends stop. The block first restores the regulator and waits a recovery count. It then keeps the clock gated for a stabilization count, and finally returns to run with the stop bit cleared. A status output reports the current phase.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, status reads 0 (run), clk_stop and reg_low are 0, and the registers at addresses 0 to 3 all read 00h.
- R2: Writing C9h to address 0 (key) opens a window that covers exactly the next bus write. A write of 01h to address 1 (regulator select) made as that next write arms the option, and address 1 bit 0 reads 1. Any other intervening write closes the window.
- R3: A write to address 1 made without an open window leaves the option unchanged and sets the error flag (address 0 bit 0). Writing 00h to address 0 clears the flag and closes the window.
- R4: Writing 1 to bit 0 of address 3 (control) while in run, with mode (address 2 bits 1:0) equal to 01 or 11 and irq_pend low, moves status to 1 (entry delay). clk_stop rises after exactly SETTLE_CYC cycles in that phase, and SETTLE_CYC is at least 5.
- R5: With mode 00 or 10, a stop write leaves status at 0, clk_stop low and address 3 reading 00h.
- R6: If irq_pend is high during the stop write, the request is dropped: status stays 0 and address 3 reads 00h.
- R7: In stop (status 2), reg_low equals the armed option, and clk_stop is 1. reg_low is 0 in every other phase.
- R8: When wake is high in stop, the block moves to regulator recovery (status 3, reg_low 0, clock still stopped) for REC_CYC cycles. It then moves to clock stabilization (status 4) for STAB_CYC cycles, then to run with clk_stop 0 and address 3 reading 00h.
- R9: If irq_pend rises during the entry delay, the block returns to run on the next cycle, the clock never stops, and the stop bit clears.
- R10: Status codes are: 0 run, 1 entry delay, 2 stop, 3 regulator recovery, 4 clock stabilization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq_pend | input | 1 | An unmasked interrupt is pending |
| wake | input | 1 | Wake-up interrupt during stop |
| clk_stop | output | 1 | Gate the main clock |
| reg_low | output | 1 | Regulator at low-voltage level |
| status | output | 3 | Current phase code |

## Verification
The stop request is driven with every mode encoding. Mode values 01 and 11 must both start entry, and 00 and 10 must both be refused, which separates a check of bit 0 from a check of the whole field. The request is also driven with a waiting interrupt and with an interrupt that arrives in the middle of the entry delay, which separates refusal at the request from abort after it. Full stop cycles are run with the option armed and with it clear, and the phase lengths are counted cycle by cycle. The key sequence is tried in its correct order, with no unlock, and with an unrelated write placed between unlock and select, which shows that the window lasts exactly one write.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_DELAY   = 3'd1,
      ST_STOP    = 3'd2,
      ST_REGREC  = 3'd3,
      ST_CLKSTAB = 3'd4
   } stby_state_e;

   localparam logic [1:0] A_KEY   = 2'd0;
   localparam logic [1:0] A_LVSEL = 2'd1;
   localparam logic [1:0] A_MODE  = 2'd2;
   localparam logic [1:0] A_CTRL  = 2'd3;

   localparam logic [7:0] KEY_OPEN  = 8'hC9;
   localparam logic [7:0] KEY_CLOSE = 8'h00;
   localparam logic [7:0] LV_ARM    = 8'h01;
endpackage

// File: rtl/stby_prot.sv
module stby_prot
   import stby_pkg::*;
#(
   parameter bit LV_ENABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic       lv_q,
   output logic       err_q
);
   logic win_q;
   logic wr_key, wr_lv;

   assign wr_key = wr_en && (addr == A_KEY);
   assign wr_lv  = wr_en && (addr == A_LVSEL);

   // window lasts for exactly one write after the key byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     win_q <= 1'b0;
      else if (wr_en) win_q <= wr_key && (wdata == KEY_OPEN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  err_q <= 1'b0;
      else if (wr_lv && !win_q)                    err_q <= 1'b1;
      else if (wr_key && (wdata == KEY_CLOSE))     err_q <= 1'b0;
   end

   generate
      if (LV_ENABLE) begin : g_lv
         logic lv_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               lv_r <= 1'b0;
            else if (wr_lv && win_q)  lv_r <= (wdata == LV_ARM);
         end
         assign lv_q = lv_r;
      end else begin : g_no_lv
         assign lv_q = 1'b0;
      end
   endgenerate

   p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lv && !win_q) |=> ($stable(lv_q) && err_q));

   p_window_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q && wr_en && !wr_key) |=> !win_q);

   p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && (wdata == KEY_CLOSE)) |=> (!err_q && !win_q));
endmodule

// File: rtl/stby_seq.sv
module stby_seq
   import stby_pkg::*;
#(
   parameter int SETTLE_CYC = 5,
   parameter int REC_CYC    = 4,
   parameter int STAB_CYC   = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        stop_req,
   input  logic        irq_pend,
   input  logic        wake,
   input  logic        lv_sel,
   output stby_state_e state,
   output logic        stop_q,
   output logic        clk_stop,
   output logic        reg_low
);
   localparam int CNT_MAX = (SETTLE_CYC > REC_CYC)
                            ? ((SETTLE_CYC > STAB_CYC) ? SETTLE_CYC : STAB_CYC)
                            : ((REC_CYC > STAB_CYC) ? REC_CYC : STAB_CYC);
   localparam int CW = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] SET_LAST  = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] REC_LAST  = CW'(REC_CYC - 1);
   localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);

   initial begin
      a_settle_min_r4: assert (SETTLE_CYC >= 5)
         else $error("entry delay shorter than five cycles");
      a_counts_pos_r8: assert (REC_CYC >= 1 && STAB_CYC >= 1)
         else $error("recovery counts must be positive");
   end

   stby_state_e    st_q, st_d;
   logic [CW-1:0]  cnt_q, cnt_d;
   logic           stop_d;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      stop_d = stop_q;
      unique case (st_q)
         ST_RUN: begin
            cnt_d = '0;
            if (stop_req && !irq_pend) begin
               st_d   = ST_DELAY;
               stop_d = 1'b1;
            end
         end
         ST_DELAY: begin
            if (irq_pend) begin
               st_d   = ST_RUN;
               stop_d = 1'b0;
               cnt_d  = '0;
            end else if (cnt_q == SET_LAST) begin
               st_d  = ST_STOP;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_STOP: begin
            cnt_d = '0;
            if (wake) st_d = ST_REGREC;
         end
         ST_REGREC: begin
            if (cnt_q == REC_LAST) begin
               st_d  = ST_CLKSTAB;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_CLKSTAB: begin
            if (cnt_q == STAB_LAST) begin
               st_d   = ST_RUN;
               stop_d = 1'b0;
               cnt_d  = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            st_d   = ST_RUN;
            stop_d = 1'b0;
            cnt_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         cnt_q  <= '0;
         stop_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         stop_q <= stop_d;
      end
   end

   assign state    = st_q;
   assign clk_stop = (st_q == ST_STOP) || (st_q == ST_REGREC) || (st_q == ST_CLKSTAB);
   assign reg_low  = (st_q == ST_STOP) && lv_sel;

   p_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && stop_req && !irq_pend) |=> (st_q == ST_DELAY && stop_q));

   p_stop_from_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_stop) |-> ($past(st_q) == ST_DELAY));

   p_pending_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && irq_pend) |=> (st_q == ST_RUN && !stop_q));

   p_reglow_only_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_low |-> (st_q == ST_STOP && clk_stop));

   p_wake_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STOP && wake) |=> (st_q == ST_REGREC && !reg_low && clk_stop));

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DELAY && irq_pend) |=> (st_q == ST_RUN && !clk_stop && !stop_q));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
   import stby_pkg::*;
#(
   parameter int SETTLE_CYC = 5,
   parameter int REC_CYC    = 4,
   parameter int STAB_CYC   = 8,
   parameter bit LV_ENABLE  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       irq_pend,
   input  logic       wake,
   output logic       clk_stop,
   output logic       reg_low,
   output logic [2:0] status
);
   logic        lv_q, err_q, stop_q, stop_req;
   logic [1:0]  mode_q;
   stby_state_e state;

   stby_prot #(.LV_ENABLE(LV_ENABLE)) u_prot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .lv_q  (lv_q),
      .err_q (err_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mode_q <= 2'b00;
      else if (wr_en && addr == A_MODE)    mode_q <= wdata[1:0];
   end

   // modes 01 and 11 select stop; only bit 0 matters
   assign stop_req = wr_en && (addr == A_CTRL) && wdata[0] && mode_q[0]
                     && (state == ST_RUN);

   stby_seq #(
      .SETTLE_CYC (SETTLE_CYC),
      .REC_CYC    (REC_CYC),
      .STAB_CYC   (STAB_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_req (stop_req),
      .irq_pend (irq_pend),
      .wake     (wake),
      .lv_sel   (lv_q),
      .state    (state),
      .stop_q   (stop_q),
      .clk_stop (clk_stop),
      .reg_low  (reg_low)
   );

   assign status = state;

   always_comb begin
      unique case (addr)
         A_KEY:   rdata = {7'd0, err_q};
         A_LVSEL: rdata = {7'd0, lv_q};
         A_MODE:  rdata = {6'd0, mode_q};
         default: rdata = {7'd0, stop_q};
      endcase
   end

   p_bad_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && wr_en && addr == A_CTRL && !mode_q[0]) |=> (status == 3'd0 && !stop_q));

   p_status_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status <= 3'd4);
endmodule

// File: tb/stby_ctrl_bench.sv
module stby_ctrl_bench;
   localparam int SETTLE = 6;
   localparam int REC    = 3;
   localparam int STAB   = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq_pend = 1'b0;
   logic       wake = 1'b0;
   logic       clk_stop, reg_low;
   logic [2:0] status;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   stby_ctrl #(.SETTLE_CYC(SETTLE), .REC_CYC(REC), .STAB_CYC(STAB), .LV_ENABLE(1'b1)) u_stby_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_pend(irq_pend), .wake(wake),
      .clk_stop(clk_stop), .reg_low(reg_low), .status(status)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 status", status, 0);
      check("R1 clk_stop", clk_stop, 0);
      check("R1 reg_low", reg_low, 0);
      for (int i = 0; i < 4; i++) begin
         bus_rd(2'(i), v);
         check("R1 reg read", v, 0);
      end
   endtask

   task automatic t_locked_write();
      logic [7:0] v;
      bus_wr(2'd1, 8'h01);
      bus_rd(2'd1, v); check("R3 option unchanged", v, 0);
      bus_rd(2'd0, v); check("R3 error set", v, 1);
      bus_wr(2'd0, 8'h00);
      bus_rd(2'd0, v); check("R3 error cleared", v, 0);
   endtask

   task automatic t_unlock();
      logic [7:0] v;
      bus_wr(2'd0, 8'hC9);
      bus_wr(2'd1, 8'h01);
      bus_wr(2'd0, 8'h00);
      bus_rd(2'd1, v); check("R2 option armed", v, 1);
      bus_rd(2'd0, v); check("R2 no error", v, 0);
   endtask

   task automatic t_window_once();
      logic [7:0] v;
      bus_wr(2'd0, 8'hC9);
      bus_wr(2'd2, 8'h03);
      bus_wr(2'd1, 8'h00);
      bus_rd(2'd1, v); check("R2 window consumed", v, 1);
      bus_rd(2'd0, v); check("R2 late write flagged", v, 1);
      bus_wr(2'd0, 8'h00);
   endtask

   task automatic t_stop_cycle(input logic [1:0] mode, input int exp_low);
      logic [7:0] v;
      int n;
      bus_wr(2'd2, {6'd0, mode});
      bus_wr(2'd3, 8'h01);
      check("R10 delay code", status, 1);
      bus_rd(2'd3, v); check("R4 stop bit set", v, 1);
      n = 0;
      while (status == 3'd1 && n < 100) begin n++; @(negedge clk); end
      check("R4 entry delay length", n, SETTLE);
      check("R7 stop code", status, 2);
      check("R7 clk_stop in stop", clk_stop, 1);
      check("R7 reg_low in stop", reg_low, exp_low);
      repeat (3) @(negedge clk);
      check("R8 stays stopped", status, 2);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      check("R8 recovery code", status, 3);
      check("R8 regulator normal", reg_low, 0);
      check("R8 clock held", clk_stop, 1);
      n = 0;
      while (status == 3'd3 && n < 100) begin n++; @(negedge clk); end
      check("R8 recovery length", n, REC);
      check("R8 stabilize code", status, 4);
      n = 0;
      while (status == 3'd4 && n < 100) begin
         n++;
         if (clk_stop != 1'b1) check("R8 clock held in stabilize", clk_stop, 1);
         @(negedge clk);
      end
      check("R8 stabilize length", n, STAB);
      check("R8 back to run", status, 0);
      check("R8 clock released", clk_stop, 0);
      bus_rd(2'd3, v); check("R8 stop bit cleared", v, 0);
   endtask

   task automatic t_bad_mode(input logic [1:0] mode);
      logic [7:0] v;
      bus_wr(2'd2, {6'd0, mode});
      bus_wr(2'd3, 8'h01);
      check("R5 status run", status, 0);
      repeat (SETTLE + 2) @(negedge clk);
      check("R5 clock running", clk_stop, 0);
      bus_rd(2'd3, v); check("R5 stop bit clear", v, 0);
   endtask

   task automatic t_pending();
      logic [7:0] v;
      bus_wr(2'd2, 8'h01);
      irq_pend = 1'b1;
      bus_wr(2'd3, 8'h01);
      irq_pend = 1'b0;
      check("R6 status run", status, 0);
      bus_rd(2'd3, v); check("R6 stop bit clear", v, 0);
      repeat (SETTLE + 2) @(negedge clk);
      check("R6 clock running", clk_stop, 0);
   endtask

   task automatic t_abort();
      logic [7:0] v;
      bus_wr(2'd2, 8'h03);
      bus_wr(2'd3, 8'h01);
      repeat (2) @(negedge clk);
      check("R9 still delaying", status, 1);
      irq_pend = 1'b1;
      @(negedge clk);
      irq_pend = 1'b0;
      check("R9 aborted to run", status, 0);
      repeat (SETTLE + 2) @(negedge clk);
      check("R9 clock never stopped", clk_stop, 0);
      bus_rd(2'd3, v); check("R9 stop bit clear", v, 0);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 20000) begin @(posedge clk); cyc++; end
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked_write();
      t_stop_cycle(2'b11, 0);
      t_unlock();
      t_window_once();
      t_stop_cycle(2'b01, 1);
      t_bad_mode(2'b00);
      t_bad_mode(2'b10);
      t_pending();
      t_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule